// File: doc/BRIEF.md
# Interleaved I/Q Sample Demultiplexer

This block sits at the input of a dual-channel converter datapath. It takes 14-bit sample words from the pins and sorts them into an in-phase (I) word and a quadrature (Q) word. The two words are then presented together as one registered pair. It works in one of two port configurations, chosen by a static mode input.

In one-port mode, I and Q words take turns on a single bus, and a steering line marks each word as I or Q. An I word is held in a pending register. The Q word that follows completes the pair. In two-port mode, each word period carries a full pair: the first bus holds I and the second bus holds Q. In this mode the steering line stops steering and becomes the most significant bit of the Q word.

The block runs on a core clock at twice the word rate. It derives two clocks from it:
- a port clock at the word rate, which is twice the per-channel rate. A source uses it to drive interleaved words.
- a data clock at the per-channel rate.

Top module: `iq_demux`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears `i_word_o`, `q_word_o`, `pair_valid_o`, `port_clk_o` and `data_clk_o` to 0 and forgets any pending I word.
- R2: In one-port mode (`two_port_i` = 0), a word sampled with `sel_msb_i` = 1 is stored as the pending I word and leaves all outputs unchanged.
- R3: In one-port mode, a word sampled with `sel_msb_i` = 0 while an I word is pending loads `i_word_o` with the pending I and `q_word_o` with the sampled word, raises `pair_valid_o` for the next clock cycle, and clears the pending state.
- R4: In one-port mode, a word sampled with `sel_msb_i` = 0 while no I word is pending is discarded: outputs hold and `pair_valid_o` stays 0.
- R5: Two I words sampled in a row in one-port mode leave only the later one pending, and it is the one paired with the next Q.
- R6: In two-port mode, every sampled word loads `i_word_o` from `p1_i` and `q_word_o` from `{sel_msb_i, p2_i}`, with `sel_msb_i` as bit 13, and pulses `pair_valid_o` for one cycle.
- R7: Words are sampled at every second rising edge of `clk`, starting at the first edge after reset is released. In one-port mode `port_clk_o` toggles on every clock edge and rises at each sampling edge. In two-port mode it is held at 0.
- R8: In one-port mode `data_clk_o` toggles at each sampling edge, giving half the port clock rate. In two-port mode it follows the word-rate phase: low before a sampling edge and high after one.
- R9: `pair_valid_o` is never high in two consecutive cycles, and `i_word_o`/`q_word_o` change only in a cycle where `pair_valid_o` is high.
- R10: Any cycle spent in two-port mode discards a pending one-port I word, so a Q word arriving after a return to one-port mode is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the word rate |
| rst | input | 1 | Synchronous active-high reset |
| two_port_i | input | 1 | 0 = one shared bus, 1 = separate I and Q buses |
| sel_msb_i | input | 1 | One-port: 1 steers to I, 0 to Q; two-port: Q bit 13 |
| p1_i | input | 14 | First bus: interleaved words, or the I word |
| p2_i | input | 13 | Second bus, bits 12..0 of the Q word (two-port) |
| i_word_o | output | 14 | Registered I word of the last pair |
| q_word_o | output | 14 | Registered Q word of the last pair |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| port_clk_o | output | 1 | Word-rate clock (one-port), else 0 |
| data_clk_o | output | 1 | Per-channel-rate clock |

## Verification
Several rules are checked on every cycle:
- the strobe is never high in two cycles running;
- the output words never change without the strobe;
- a presented pair matches the words sampled one edge earlier, for both port modes;
- the port clock toggles steadily in one-port mode;
- the data clock moves only at a sampling edge.

Some behaviours depend on history that spans several words, and only the bench's scenarios show them: a Q word dropped when no I is pending, the later of two I words winning, and a pending I being discarded by a trip through two-port mode. A behavioural model in the bench covers these, and it also covers reset clearing and the data values.

// File: rtl/iqdm_pkg.sv
package iqdm_pkg;
   typedef enum logic {
      PORTS_ONE = 1'b0,
      PORTS_TWO = 1'b1
   } port_mode_e;
endpackage

// File: rtl/iqdm_clkgen.sv
module iqdm_clkgen
   import iqdm_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  port_mode_e mode,
   output logic       strobe_o,
   output logic       port_clk_o,
   output logic       data_clk_o
);
   logic phase_q;
   logic chan_q;
   logic live_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= 1'b0;
         chan_q  <= 1'b0;
         live_q  <= 1'b0;
      end else begin
         phase_q <= ~phase_q;
         live_q  <= 1'b1;
         if (!phase_q && mode == PORTS_ONE)
            chan_q <= ~chan_q;
      end
   end

   // sampling edge is the one where the word-rate phase goes 0 -> 1
   assign strobe_o   = ~phase_q;
   assign port_clk_o = (mode == PORTS_TWO) ? 1'b0 : phase_q;
   assign data_clk_o = (mode == PORTS_TWO) ? phase_q : chan_q;

   // R7: steady toggle of the port clock while one-port mode holds
   a_r7_port_clk_toggles: assert property (@(posedge clk) disable iff (rst)
      (live_q && mode == PORTS_ONE && $past(mode) == PORTS_ONE)
         |-> (port_clk_o != $past(port_clk_o)));

   // R8: data clock moves only right after a sampling edge
   a_r8_data_clk_on_strobe: assert property (@(posedge clk) disable iff (rst)
      (live_q && mode == PORTS_ONE && $past(mode) == PORTS_ONE
         && !$stable(data_clk_o)) |-> $past(strobe_o));
endmodule

// File: rtl/iqdm_steer.sv
module iqdm_steer
   import iqdm_pkg::*;
#(
   parameter int W          = 14,
   parameter bit SEL_I_HIGH = 1'b1
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         strobe,
   input  port_mode_e   mode,
   input  logic         sel,
   input  logic [W-1:0] p1,
   input  logic [W-2:0] p2lo,
   output logic [W-1:0] i_o,
   output logic [W-1:0] q_o,
   output logic         pv_o
);
   logic         is_i;
   logic [W-1:0] pend_q;
   logic         seen_q;
   logic         live_q;

   generate
      if (SEL_I_HIGH) begin : g_pol_high
         assign is_i = sel;
      end else begin : g_pol_low
         assign is_i = ~sel;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
         seen_q <= 1'b0;
         i_o    <= '0;
         q_o    <= '0;
         pv_o   <= 1'b0;
         live_q <= 1'b0;
      end else begin
         live_q <= 1'b1;
         pv_o   <= 1'b0;
         if (mode == PORTS_TWO)
            seen_q <= 1'b0;
         if (strobe) begin
            if (mode == PORTS_TWO) begin
               i_o  <= p1;
               q_o  <= {sel, p2lo};
               pv_o <= 1'b1;
            end else if (is_i) begin
               pend_q <= p1;
               seen_q <= 1'b1;
            end else if (seen_q) begin
               i_o    <= pend_q;
               q_o    <= p1;
               pv_o   <= 1'b1;
               seen_q <= 1'b0;
            end
         end
      end
   end

   // R9: strobe is a single-cycle pulse
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
      pv_o |=> !pv_o);

   // R9: output words move only together with the strobe
   a_r9_words_need_strobe: assert property (@(posedge clk) disable iff (rst)
      (live_q && (!$stable(i_o) || !$stable(q_o))) |-> pv_o);

   // R3: one-port pair closes on a Q-steered word taken from the shared bus
   a_r3_q_from_bus: assert property (@(posedge clk) disable iff (rst)
      (live_q && pv_o && $past(mode) == PORTS_ONE)
         |-> (q_o == $past(p1) && !$past(is_i)));

   // R6: two-port pair takes both buses, steering line as Q MSB
   a_r6_two_port_word: assert property (@(posedge clk) disable iff (rst)
      (live_q && pv_o && $past(mode) == PORTS_TWO)
         |-> (i_o == $past(p1) && q_o == {$past(sel), $past(p2lo)}));
endmodule

// File: rtl/iq_demux.sv
module iq_demux
   import iqdm_pkg::*;
#(
   parameter int W          = 14,
   parameter bit SEL_I_HIGH = 1'b1
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         two_port_i,
   input  logic         sel_msb_i,
   input  logic [W-1:0] p1_i,
   input  logic [W-2:0] p2_i,
   output logic [W-1:0] i_word_o,
   output logic [W-1:0] q_word_o,
   output logic         pair_valid_o,
   output logic         port_clk_o,
   output logic         data_clk_o
);
   localparam int P2W = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("iq_demux: W must be at least 2");
      end
      if (P2W + 1 != W) begin : g_bad_split
         $error("iq_demux: second bus split mismatch");
      end
   endgenerate

   port_mode_e mode;
   logic       strobe;

   assign mode = two_port_i ? PORTS_TWO : PORTS_ONE;

   iqdm_clkgen u_clk (
      .clk        (clk),
      .rst        (rst),
      .mode       (mode),
      .strobe_o   (strobe),
      .port_clk_o (port_clk_o),
      .data_clk_o (data_clk_o)
   );

   iqdm_steer #(
      .W          (W),
      .SEL_I_HIGH (SEL_I_HIGH)
   ) u_steer (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .mode   (mode),
      .sel    (sel_msb_i),
      .p1     (p1_i),
      .p2lo   (p2_i),
      .i_o    (i_word_o),
      .q_o    (q_word_o),
      .pv_o   (pair_valid_o)
   );
endmodule

// File: tb/sim_iq_demux.sv
`timescale 1ns/1ps
module sim_iq_demux;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        two_port_i = 1'b0;
   logic        sel_msb_i = 1'b0;
   logic [13:0] p1_i = '0;
   logic [12:0] p2_i = '0;
   logic [13:0] i_word_o, q_word_o;
   logic        pair_valid_o, port_clk_o, data_clk_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   string cur_tag = "R1";

   always #2.5 clk = ~clk;

   iq_demux u0 (
      .clk(clk), .rst(rst), .two_port_i(two_port_i), .sel_msb_i(sel_msb_i),
      .p1_i(p1_i), .p2_i(p2_i), .i_word_o(i_word_o), .q_word_o(q_word_o),
      .pair_valid_o(pair_valid_o), .port_clk_o(port_clk_o), .data_clk_o(data_clk_o)
   );

   // behavioural reference model
   bit        m_ph, m_dc, m_seen, m_pv;
   bit [13:0] m_pend, m_i, m_q;

   always @(posedge clk) begin
      if (rst) begin
         m_ph = 0; m_dc = 0; m_seen = 0; m_pv = 0;
         m_pend = 0; m_i = 0; m_q = 0;
      end else begin
         bit strb;
         strb = !m_ph;
         m_pv = 0;
         if (two_port_i) m_seen = 0;
         if (strb) begin
            if (two_port_i) begin
               m_i = p1_i; m_q = {sel_msb_i, p2_i}; m_pv = 1;
            end else if (sel_msb_i) begin
               m_pend = p1_i; m_seen = 1;
            end else if (m_seen) begin
               m_i = m_pend; m_q = p1_i; m_pv = 1; m_seen = 0;
            end
            if (!two_port_i) m_dc = !m_dc;
         end
         m_ph = !m_ph;
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // compare every cycle, 1 ns after the negedge where inputs change
   always begin
      @(negedge clk);
      #1;
      if (!rst && !done) begin
         check(cur_tag, "i_word", i_word_o, m_i);
         check(cur_tag, "q_word", q_word_o, m_q);
         check("R9", "pair_valid", pair_valid_o, m_pv);
         check("R7", "port_clk", port_clk_o, two_port_i ? 0 : m_ph);
         check("R8", "data_clk", data_clk_o, two_port_i ? m_ph : m_dc);
      end
   end

   task automatic put(input bit s, input logic [13:0] d);
      @(negedge clk);
      while (m_ph) @(negedge clk);
      sel_msb_i = s;
      p1_i = d;
   endtask

   task automatic put2(input logic [13:0] di, input logic [13:0] dq);
      @(negedge clk);
      while (m_ph) @(negedge clk);
      p1_i = di;
      sel_msb_i = dq[13];
      p2_i = dq[12:0];
   endtask

   task automatic finish_run();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      #1;
      check("R1", "i_word reset", i_word_o, 0);
      check("R1", "q_word reset", q_word_o, 0);
      check("R1", "pair_valid reset", pair_valid_o, 0);
      check("R1", "port_clk reset", port_clk_o, 0);
      check("R1", "data_clk reset", data_clk_o, 0);
      @(negedge clk); rst = 0;

      cur_tag = "R2";           // I only, outputs must hold
      put(1, 14'h1234);
      put(1, 14'h0ABC);
      cur_tag = "R5";           // later I wins
      put(1, 14'h2222);
      put(0, 14'h3333);
      cur_tag = "R3";           // normal pairs
      put(1, 14'h3FFF); put(0, 14'h0000);
      put(1, 14'h0001); put(0, 14'h2AAA);
      put(1, 14'h1555); put(0, 14'h3FFF);
      cur_tag = "R4";           // Q without pending I dropped
      put(0, 14'h0777);
      put(0, 14'h0888);
      cur_tag = "R6";           // two-port words
      @(negedge clk); two_port_i = 1;
      put2(14'h0101, 14'h2F0F);
      put2(14'h3FFF, 14'h3FFF);
      put2(14'h0000, 14'h1000);
      put2(14'h1ABC, 14'h0DEF);
      cur_tag = "R10";          // pending I discarded by two-port visit
      @(negedge clk); two_port_i = 0;
      put(1, 14'h0AAA);
      @(negedge clk); two_port_i = 1;
      repeat (2) @(negedge clk);
      two_port_i = 0;
      put(0, 14'h0555);
      put(0, 14'h0666);
      cur_tag = "R3";           // random one-port traffic
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         sel_msb_i = 1'($urandom);
         p1_i = 14'($urandom);
         p2_i = 13'($urandom);
      end
      cur_tag = "R6";           // random two-port traffic
      two_port_i = 1;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         sel_msb_i = 1'($urandom);
         p1_i = 14'($urandom);
         p2_i = 13'($urandom);
      end
      // R1: mid-run reset clears outputs and pending state
      cur_tag = "R1";
      two_port_i = 0;
      put(1, 14'h1111);
      @(negedge clk); rst = 1;
      @(negedge clk); #1;
      check("R1", "i_word after reset", i_word_o, 0);
      check("R1", "q_word after reset", q_word_o, 0);
      check("R1", "pair_valid after reset", pair_valid_o, 0);
      @(negedge clk); rst = 0;
      cur_tag = "R4";
      put(0, 14'h0123);
      put(0, 14'h0124);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule